// File: doc/BRIEF.md
# Status Word Interrupt Controller

This block keeps the 128-bit processor status word and decides, cycle by cycle, whether a pending interrupt is taken. Six interrupt classes feed it. Machine check, external and I/O requests arrive as vectors of subclass conditions. Event-recording conditions are folded into the program class. Supervisor call, program and restart arrive as single lines. The masked classes are gated twice: once by an enable bit in the status word and once by a subclass mask supplied from a control register.

When a request is accepted, the block runs a fixed swap. It writes the current word to the class's old-word slot, reads the class's new-word slot, and installs the returned word. A load command replaces the whole word from an arbitrary storage address. An instruction-advance strobe tells the execution pipeline when it may proceed. The wait bit in the word stops it until an interrupt arrives.

Bit positions are counted from the most significant end: `status_word[0]` is the leftmost bit. Storage is word-wide, 128 bits per address.

The storage request channel uses valid/ready. A request, with its write enable, address and data, is held unchanged while `mem_req_ready` is low. Responses carry no ready signal and are always accepted. At most one read is outstanding. The load command is a valid/ready handshake of its own.

Top module: `swc_top`

## Requirements
- R1: After reset, `status_word` equals RESET_WORD (default all zero). `wait_state` is 0, `adv_en` and `ld_ready` are 1, and `mem_req_valid` and `intr_taken` are 0.
- R2: I/O (class code 5) is accepted only when `status_word[6]` is 1 and some bit i of `io_req` has bit i of `io_mask` set.
- R3: External (class code 4) is accepted only when `status_word[7]` is 1 and some bit i of `ext_req` has bit i of `ext_mask` set.
- R4: Machine check (class code 0) needs `status_word[13]` = 1. Bits 0 (system damage) and 1 (processing damage) of `mchk_req` need no mask bit. Every other bit i also needs bit i of `mchk_mask`.
- R5: Bit i of `evt_req` raises a program-class request (code 2) only when `status_word[1]` is 1 and bit i of `evt_mask` is 1.
- R6: `svc_req` (code 1), `pgm_req` (code 2) and `restart_req` (code 3) are accepted whatever the word and the masks hold.
- R7: Among pending enabled classes, the lowest code wins: machine check 0, supervisor call 1, program 2, restart 3, external 4, I/O 5. Requests are sampled while the block is idle. `intr_taken` pulses the following cycle with the winner on `intr_class`.
- R8: An accepted interrupt of code c first writes the current word to address SLOT_BASE+2c, then reads SLOT_BASE+2c+1. The returned word becomes `status_word`.
- R9: `adv_en` is low from the acceptance cycle until the new word is installed. It returns high once the block is idle, nothing is being accepted and the word is not waiting.
- R10: While `status_word[14]` is 1, `wait_state` is 1 and `adv_en` and `ld_ready` are 0. Load commands are ignored and the word stays unchanged. Only an accepted interrupt leaves this state.
- R11: A load accepted on `ld_valid && ld_ready` reads `ld_addr`, and the returned 128 bits replace the word. The word changes only on a storage response to the block's own read.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request's write enable, address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mchk_req | input | NSUB | Pending machine-check subclass conditions |
| mchk_mask | input | NSUB | Machine-check subclass mask register |
| svc_req | input | 1 | Supervisor-call request |
| pgm_req | input | 1 | Program exception request |
| evt_req | input | NSUB | Pending event-recording conditions |
| evt_mask | input | NSUB | Event mask register |
| restart_req | input | 1 | Restart request |
| ext_req | input | NSUB | Pending external subclass conditions |
| ext_mask | input | NSUB | External subclass mask register |
| io_req | input | NSUB | Pending I/O subclass conditions |
| io_mask | input | NSUB | I/O subclass mask register |
| ld_valid | input | 1 | Load-word command valid |
| ld_ready | output | 1 | Load-word command accepted |
| ld_addr | input | AW | Storage address of the word to load |
| mem_req_valid | output | 1 | Storage request valid |
| mem_req_ready | input | 1 | Storage request accepted |
| mem_we | output | 1 | Storage request is a write |
| mem_addr | output | AW | Storage word address |
| mem_wdata | output | 128 | Storage write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rdata | input | 128 | Read response data |
| status_word | output | 128 | Current status word |
| wait_state | output | 1 | Processor is waiting |
| adv_en | output | 1 | Instruction processing may advance |
| intr_taken | output | 1 | One-cycle pulse: an interrupt was accepted |
| intr_class | output | 3 | Class code of the accepted interrupt |

## Verification
A wrong gating term shows up in the cycle after the request is applied. Either `intr_taken` rises where it should stay low, or `intr_class` names a lower-priority class. A corrupted sequencer state shows up on the storage port within one transaction: a wrong slot address, a read where a write is due, or a request that moves while stalled. It also appears as an installed word that differs from the new-word slot a few cycles later. A wait-bit fault is seen at once, as `adv_en` or `ld_ready` high while `wait_state` is high, or as a load that changes the word.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int WORD_W = 128;
  localparam int NCLS   = 6;

  // status-word bit positions, counted from the most significant end
  localparam int B_EVT  = 1;
  localparam int B_IO   = 6;
  localparam int B_EXT  = 7;
  localparam int B_MCHK = 13;
  localparam int B_WAIT = 14;

  // class code doubles as priority rank: lower code wins
  typedef enum logic [2:0] {
    CL_MCHK = 3'd0,
    CL_SVC  = 3'd1,
    CL_PGM  = 3'd2,
    CL_RST  = 3'd3,
    CL_EXT  = 3'd4,
    CL_IO   = 3'd5
  } cls_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SAVE,
    S_FETCH,
    S_RESP
  } seq_e;
endpackage

// File: rtl/swc_qual.sv
// Two-level qualification of one masked class: word enable bit, then subclass mask.
module swc_qual #(
  parameter int              NSUB   = 8,
  parameter logic [NSUB-1:0] BYPASS = '0
) (
  input  logic            en,
  input  logic [NSUB-1:0] req,
  input  logic [NSUB-1:0] mask,
  output logic            hit
);
  logic [NSUB-1:0] open_sub;

  assign open_sub = mask | BYPASS;
  assign hit      = en & (|(req & open_sub));
endmodule

// File: rtl/swc_gate.sv
module swc_gate import swc_pkg::*; #(
  parameter int NSUB = 8
) (
  input  logic [0:WORD_W-1] word,
  input  logic [NSUB-1:0]   mchk_req,
  input  logic [NSUB-1:0]   mchk_mask,
  input  logic              svc_req,
  input  logic              pgm_req,
  input  logic [NSUB-1:0]   evt_req,
  input  logic [NSUB-1:0]   evt_mask,
  input  logic              restart_req,
  input  logic [NSUB-1:0]   ext_req,
  input  logic [NSUB-1:0]   ext_mask,
  input  logic [NSUB-1:0]   io_req,
  input  logic [NSUB-1:0]   io_mask,
  output logic              take,
  output cls_e              cls
);
  // damage subclasses 0 and 1 ignore the machine-check subclass mask
  localparam logic [NSUB-1:0] MC_BYPASS = NSUB'(3);

  logic mchk_hit, evt_hit, ext_hit, io_hit;
  logic [NCLS-1:0] hit;

  swc_qual #(.NSUB(NSUB), .BYPASS(MC_BYPASS)) u_q_mchk (
    .en(word[B_MCHK]), .req(mchk_req), .mask(mchk_mask), .hit(mchk_hit));
  swc_qual #(.NSUB(NSUB), .BYPASS('0)) u_q_evt (
    .en(word[B_EVT]),  .req(evt_req),  .mask(evt_mask),  .hit(evt_hit));
  swc_qual #(.NSUB(NSUB), .BYPASS('0)) u_q_ext (
    .en(word[B_EXT]),  .req(ext_req),  .mask(ext_mask),  .hit(ext_hit));
  swc_qual #(.NSUB(NSUB), .BYPASS('0)) u_q_io (
    .en(word[B_IO]),   .req(io_req),   .mask(io_mask),   .hit(io_hit));

  // bit index equals class code
  assign hit = {io_hit, ext_hit, restart_req, pgm_req | evt_hit, svc_req, mchk_hit};

  always_comb begin
    take = 1'b0;
    cls  = CL_MCHK;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        take = 1'b1;
        cls  = cls_e'(i);
      end
    end
  end
endmodule

// File: rtl/swc_seq.sv
module swc_seq import swc_pkg::*; #(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] SLOT_BASE = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  cls_e              cls,
  input  logic              wait_bit,
  input  logic [0:WORD_W-1] cur_word,
  input  logic              ld_valid,
  input  logic [AW-1:0]     ld_addr,
  output logic              ld_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [0:WORD_W-1] mem_wdata,
  input  logic              mem_rsp_valid,
  output logic              load_en,
  output logic              adv_en,
  output logic              intr_taken,
  output logic [2:0]        intr_class
);
  seq_e          st;
  cls_e          cls_q;
  logic          from_intr;
  logic [AW-1:0] addr_q;
  logic          taken_q;
  logic          idle_free;

  function automatic logic [AW-1:0] slot_addr(input cls_e c, input logic new_slot);
    return SLOT_BASE + AW'({c, new_slot});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cls_q     <= CL_MCHK;
      from_intr <= 1'b0;
      addr_q    <= '0;
      taken_q   <= 1'b0;
    end else begin
      taken_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (take) begin
            st        <= S_SAVE;
            cls_q     <= cls;
            from_intr <= 1'b1;
            taken_q   <= 1'b1;
          end else if (ld_valid && !wait_bit) begin
            st        <= S_FETCH;
            addr_q    <= ld_addr;
            from_intr <= 1'b0;
          end
        end
        S_SAVE:  if (mem_req_ready) st <= S_FETCH;
        S_FETCH: if (mem_req_ready) st <= S_RESP;
        S_RESP:  if (mem_rsp_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle_free     = (st == S_IDLE) && !take && !wait_bit;
  assign ld_ready      = idle_free;
  assign adv_en        = idle_free;
  assign mem_req_valid = (st == S_SAVE) || (st == S_FETCH);
  assign mem_we        = (st == S_SAVE);
  assign mem_wdata     = cur_word;
  assign load_en       = (st == S_RESP) && mem_rsp_valid;
  assign intr_taken    = taken_q;
  assign intr_class    = cls_q;

  always_comb begin
    if (st == S_SAVE)  mem_addr = slot_addr(cls_q, 1'b0);
    else if (from_intr) mem_addr = slot_addr(cls_q, 1'b1);
    else               mem_addr = addr_q;
  end
endmodule

// File: rtl/swc_top.sv
module swc_top import swc_pkg::*; #(
  parameter int                NSUB       = 8,
  parameter int                AW         = 16,
  parameter logic [AW-1:0]     SLOT_BASE  = 16'h0010,
  parameter logic [0:WORD_W-1] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSUB-1:0]   mchk_req,
  input  logic [NSUB-1:0]   mchk_mask,
  input  logic              svc_req,
  input  logic              pgm_req,
  input  logic [NSUB-1:0]   evt_req,
  input  logic [NSUB-1:0]   evt_mask,
  input  logic              restart_req,
  input  logic [NSUB-1:0]   ext_req,
  input  logic [NSUB-1:0]   ext_mask,
  input  logic [NSUB-1:0]   io_req,
  input  logic [NSUB-1:0]   io_mask,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [0:WORD_W-1] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [0:WORD_W-1] mem_rdata,
  output logic [0:WORD_W-1] status_word,
  output logic              wait_state,
  output logic              adv_en,
  output logic              intr_taken,
  output logic [2:0]        intr_class
);
  logic [0:WORD_W-1] word_q;
  logic              take;
  cls_e              cls;
  logic              load_en;

  swc_gate #(.NSUB(NSUB)) u_gate (
    .word(word_q),
    .mchk_req(mchk_req), .mchk_mask(mchk_mask),
    .svc_req(svc_req), .pgm_req(pgm_req),
    .evt_req(evt_req), .evt_mask(evt_mask),
    .restart_req(restart_req),
    .ext_req(ext_req), .ext_mask(ext_mask),
    .io_req(io_req), .io_mask(io_mask),
    .take(take), .cls(cls)
  );

  swc_seq #(.AW(AW), .SLOT_BASE(SLOT_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .take(take), .cls(cls),
    .wait_bit(word_q[B_WAIT]), .cur_word(word_q),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .load_en(load_en), .adv_en(adv_en),
    .intr_taken(intr_taken), .intr_class(intr_class)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= RESET_WORD;
    else if (load_en) word_q <= mem_rdata;
  end

  assign status_word = word_q;
  assign wait_state  = word_q[B_WAIT];
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] SLOT_BASE = 16'h0010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [0:127]  mem_wdata,
  input logic          mem_rsp_valid,
  input logic [0:127]  status_word,
  input logic          wait_state,
  input logic          adv_en,
  input logic          ld_ready,
  input logic          intr_taken,
  input logic [2:0]    intr_class
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_we)
      && $stable(mem_addr) && $stable(mem_wdata));

  // R10
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_state |-> !adv_en && !ld_ready);

  // R9
  busy_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !adv_en);

  // R8
  old_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_taken |-> mem_req_valid && mem_we
      && mem_addr == SLOT_BASE + AW'({intr_class, 1'b0}));

  // R11
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |=> $stable(status_word));
endmodule

bind swc_top swc_chk #(.AW(AW), .SLOT_BASE(SLOT_BASE)) u_swc_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rsp_valid(mem_rsp_valid), .status_word(status_word),
  .wait_state(wait_state), .adv_en(adv_en), .ld_ready(ld_ready),
  .intr_taken(intr_taken), .intr_class(intr_class)
);

// File: tb/test_swc_top.sv
`timescale 1ns/1ps
module test_swc_top;
  localparam int NS = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] SB = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] mchk_req = '0, mchk_mask = '0, evt_req = '0, evt_mask = '0;
  logic [NS-1:0] ext_req = '0, ext_mask = '0, io_req = '0, io_mask = '0;
  logic svc_req = 1'b0, pgm_req = 1'b0, restart_req = 1'b0;
  logic ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic ld_ready, mem_req_valid, mem_we, wait_state, adv_en, intr_taken;
  logic mem_req_ready = 1'b1;
  logic mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [0:127] mem_wdata, status_word;
  logic [0:127] mem_rdata = '0;
  logic [2:0] intr_class;

  int checks = 0;
  int errors = 0;

  logic [0:127] mem [0:63];
  int rsp_cnt = 0;
  logic [AW-1:0] rd_addr = '0, wr_log = '0, rd_log = '0, hold_addr = '0;
  logic hold_pend = 1'b0;
  int bp_err = 0;

  always #10 clk = ~clk;

  swc_top #(.NSUB(NS), .AW(AW), .SLOT_BASE(SB)) i_swc_top (
    .clk(clk), .rst_n(rst_n),
    .mchk_req(mchk_req), .mchk_mask(mchk_mask),
    .svc_req(svc_req), .pgm_req(pgm_req),
    .evt_req(evt_req), .evt_mask(evt_mask),
    .restart_req(restart_req),
    .ext_req(ext_req), .ext_mask(ext_mask),
    .io_req(io_req), .io_mask(io_mask),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .status_word(status_word), .wait_state(wait_state), .adv_en(adv_en),
    .intr_taken(intr_taken), .intr_class(intr_class)
  );

  // storage model: random stalls, read latency of three edges, stall monitor (R12)
  always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (rsp_cnt != 0) begin
      rsp_cnt <= rsp_cnt - 1;
      if (rsp_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rdata     <= mem[rd_addr[5:0]];
      end
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    if (hold_pend && (!mem_req_valid || mem_addr != hold_addr)) bp_err <= bp_err + 1;
    if (mem_req_valid && !mem_req_ready) begin
      hold_pend <= 1'b1;
      hold_addr <= mem_addr;
    end else begin
      hold_pend <= 1'b0;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        mem[mem_addr[5:0]] <= mem_wdata;
        wr_log <= mem_addr;
      end else begin
        rd_addr <= mem_addr;
        rd_log  <= mem_addr;
        rsp_cnt <= 2;
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected winning class from the requirements; 7 means nothing taken
  function automatic int exp_cls(input logic [0:127] w, input logic [NS-1:0] mc, mm,
                                 input logic sv, pg, input logic [NS-1:0] ev, em,
                                 input logic rs, input logic [NS-1:0] ex, xm, io, im);
    if (w[13] && |(mc & (mm | NS'(3)))) return 0;   // R4
    if (sv) return 1;                               // R6
    if (pg || (w[1] && |(ev & em))) return 2;       // R5 R6
    if (rs) return 3;                               // R6
    if (w[7] && |(ex & xm)) return 4;               // R3
    if (w[6] && |(io & im)) return 5;               // R2
    return 7;
  endfunction

  task automatic clear_reqs();
    mchk_req = '0; mchk_mask = '0; evt_req = '0; evt_mask = '0;
    ext_req = '0; ext_mask = '0; io_req = '0; io_mask = '0;
    svc_req = 1'b0; pgm_req = 1'b0; restart_req = 1'b0;
  endtask

  task automatic wait_rsp(input string tag);
    int n = 0;
    while (!mem_rsp_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (n >= 400) begin
      checks++; errors++;
      $display("FAIL %s no storage response act=0 exp=1", tag);
    end
    @(negedge clk);
  endtask

  task automatic load_word(input logic [0:127] w, input logic [5:0] a);
    int n = 0;
    mem[a] = w;
    ld_addr = AW'(a);
    ld_valid = 1'b1;
    while (!ld_ready && n < 400) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    wait_rsp("R11 load");
    chk("R11 loaded word", status_word, w);
    chk("R11 read address", 128'(rd_log), 128'(a));
  endtask

  task automatic take_done(input int c, input logic [0:127] prev);
    wait_rsp("R8 swap");
    chk("R8 old slot address", 128'(wr_log), 128'(SB + AW'(2 * c)));
    chk("R8 saved word", mem[6'(SB + AW'(2 * c))], prev);
    chk("R8 new slot address", 128'(rd_log), 128'(SB + AW'(2 * c + 1)));
    chk("R8 installed word", status_word, mem[6'(SB + AW'(2 * c + 1))]);
    chk("R9 advance resumes", 128'(adv_en), 128'(1));
    chk("R10 left wait", 128'(wait_state), 128'(0));
  endtask

  task automatic exit_wait(input logic [0:127] prev);
    chk("R10 no advance while waiting", 128'(adv_en), 128'(0));
    restart_req = 1'b1;
    @(negedge clk);
    chk("R10 restart taken", 128'(intr_taken), 128'(1));
    chk("R6 restart class", 128'(intr_class), 128'(3));
    clear_reqs();
    take_done(3, prev);
  endtask

  task automatic run_case(input logic [0:127] w, input logic [NS-1:0] mc, mm,
                          input logic sv, pg, input logic [NS-1:0] ev, em,
                          input logic rs, input logic [NS-1:0] ex, xm, io, im);
    int e = exp_cls(w, mc, mm, sv, pg, ev, em, rs, ex, xm, io, im);
    load_word(w, 6'd2);
    mchk_req = mc; mchk_mask = mm; svc_req = sv; pgm_req = pg;
    evt_req = ev; evt_mask = em; restart_req = rs;
    ext_req = ex; ext_mask = xm; io_req = io; io_mask = im;
    @(negedge clk);
    if (e == 7) begin
      chk("R2/R3/R4/R5 masked request not taken", 128'(intr_taken), 128'(0));
      @(negedge clk);
      chk("R2/R3/R4/R5 still not taken", 128'(intr_taken), 128'(0));
      chk("R11 word kept", status_word, w);
      clear_reqs();
      if (w[14]) exit_wait(w);
    end else begin
      chk("R7 request taken", 128'(intr_taken), 128'(1));
      chk("R7 priority class", 128'(intr_class), 128'(e));
      chk("R9 advance held off", 128'(adv_en), 128'(0));
      clear_reqs();
      take_done(e, w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [0:127] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int c = 0; c < 6; c++) begin
      w = {$urandom, $urandom, $urandom, $urandom};
      w[14] = 1'b0;
      mem[6'(SB) + 6'(2 * c + 1)] = w;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset word", status_word, '0);
    chk("R1 reset wait", 128'(wait_state), 128'(0));
    chk("R1 reset advance", 128'(adv_en), 128'(1));
    chk("R1 reset load ready", 128'(ld_ready), 128'(1));
    chk("R1 reset no request", 128'(mem_req_valid), 128'(0));
    chk("R1 reset no take", 128'(intr_taken), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R7 everything pending: machine check wins
    w = '0; w[1] = 1; w[6] = 1; w[7] = 1; w[13] = 1;
    run_case(w, 8'hff, 8'hff, 1, 1, 8'hff, 8'hff, 1, 8'hff, 8'hff, 8'hff, 8'hff);
    // R7 without machine check: supervisor call wins
    run_case(w, 8'h00, 8'hff, 1, 1, 8'hff, 8'hff, 1, 8'hff, 8'hff, 8'hff, 8'hff);
    // R4 damage subclass 0 bypasses an all-zero mask
    run_case(w, 8'h01, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4 subclass 2 blocked by mask, then passes with its mask bit
    run_case(w, 8'h04, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_case(w, 8'h04, 8'h04, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 event with word bit 1 clear is ignored; with it set goes to program class
    w[1] = 0;
    run_case(w, 0, 0, 0, 0, 8'h10, 8'h10, 0, 0, 0, 0, 0);
    w[1] = 1;
    run_case(w, 0, 0, 0, 0, 8'h10, 8'h10, 0, 0, 0, 0, 0);
    // R2 I/O enable bit clear blocks; R3 external beats I/O
    w[6] = 0;
    run_case(w, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h08, 8'h08);
    run_case(w, 0, 0, 0, 0, 0, 0, 0, 8'h20, 8'h20, 8'h08, 8'h08);
    // R6 restart with every enable bit clear
    run_case('0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R10 waiting word: load command is ignored, restart leaves
    w = '0; w[14] = 1;
    load_word(w, 6'd2);
    chk("R10 wait output", 128'(wait_state), 128'(1));
    mem[3] = ~w;
    ld_addr = AW'(3);
    ld_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R10 load refused", 128'(ld_ready), 128'(0));
    end
    ld_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 word unchanged", status_word, w);
    exit_wait(w);

    // random mix, R2 R3 R4 R5 R6 R7 R8 R10 against bench model
    for (int it = 0; it < 60; it++) begin
      w = {$urandom, $urandom, $urandom, $urandom};
      w[14] = ($urandom % 5) == 0;
      run_case(w, NS'($urandom & $urandom), NS'($urandom),
               ($urandom % 6) == 0, ($urandom % 6) == 0,
               NS'($urandom & $urandom), NS'($urandom),
               ($urandom % 6) == 0,
               NS'($urandom & $urandom), NS'($urandom),
               NS'($urandom & $urandom), NS'($urandom));
    end

    chk("R12 stalled request stable", 128'(bp_err), 128'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule